// File: doc/BRIEF.md
# Lockable Region Configuration Register File

This block is the software-visible configuration store for an inline memory cipher engine. A 32-bit register-bus master reads and writes a global control word, a privilege word and four region contexts. Each context holds a configuration word (enable, two lock bits, a 2-bit mode and a firmware version), a start address, an end address and two nonce words. The block drives the per-region state that the rest of the engine consumes.

The block enforces the access rules on its own. Lock bits can be set but never cleared except by reset. A configuration lock also forces the key lock and freezes the whole context. A mode change pulses a key-clear strobe toward the key loader. Once the privilege bit is set, unprivileged masters are shut out.

The key words and the key checksum are owned by the key loader. Reads of the key-word offsets return zero here. The checksum is only mirrored into the configuration word.

Top module: `otf_region_regfile`

## Requirements
- R1: After synchronous reset every stored field is zero, so the engine is in decryption mode, all regions are disabled and unlocked, the privilege bit is clear and no key-clear strobe is active.
- R2: Bit 0 of the control word at offset 0x00 selects encryption (1) or decryption (0). It drives `ctl_encrypt_o` and reads back in bit 0.
- R3: Region n occupies bytes 0x20+48n up to 0x20+48n+47. The configuration word is at +0x0, the start address at +0x4, the end address at +0x8 and the nonce words at +0xC and +0x10. The address and nonce words store and read back all 32 bits.
- R4: The configuration word layout is: version in 31:16, a read-only key checksum in 15:8 (mirrored from `rgn_key_crc_i`), mode in 5:4, key lock in 2, configuration lock in 1 and enable in 0. Bits 3, 7 and 6 read as zero.
- R5: Each lock bit is set by writing 1. Writing 0 never clears it. Only reset clears it.
- R6: Writing 1 to the configuration lock of a region also sets that region's key lock.
- R7: While a region's configuration lock is set, writes to its configuration, address and nonce words are ignored.
- R8: A configuration write that changes the mode produces a one-cycle pulse on that region's `rgn_key_clr_o` bit, in the cycle after the write. A write that leaves the mode unchanged produces no pulse. Once the key lock is set, the mode field ignores writes.
- R9: While the privilege bit (offset 0x10, bit 0) is set, an unprivileged access reads zero from every offset except 0x10, and its writes are ignored.
- R10: The privilege bit is written only by privileged accesses. Any master can read it.
- R11: Unmapped offsets, misaligned addresses and the key-word offsets (+0x14 to +0x2C within a region) read zero, and writes to them change nothing.
- R12: A read request returns `bus_rdata` with `bus_rvalid` high in the cycle after it is sampled. A write updates the state outputs in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, sampled on the rising edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rgn_key_crc_i | input | 8*N_RGN | Per-region key checksum from the key loader |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| ctl_encrypt_o | output | 1 | Engine in encryption mode |
| rgn_en_o | output | N_RGN | Per-region enable |
| rgn_mode_o | output | 2*N_RGN | Per-region mode |
| rgn_ver_o | output | 16*N_RGN | Per-region firmware version |
| rgn_cfg_lock_o | output | N_RGN | Per-region configuration lock |
| rgn_key_lock_o | output | N_RGN | Per-region key lock |
| rgn_key_clr_o | output | N_RGN | One-cycle key wipe strobe per region |

## Verification
The bench targets four behaviours.

- **Locks.** A design that clears a lock on a 0 write, or skips the forced key lock, would show the lock outputs dropping or staying low after a configuration-lock write.
- **Frozen contexts.** A context that is not fully frozen would read back the new start address or enable bit after the lock.
- **Mode changes.** The bench writes the same mode, a new mode and a mode under key lock. A strobe keyed to every configuration write, or one that ignores the key lock, would pulse where none is expected.
- **Privilege gating.** Unprivileged accesses are tested with the privilege bit set and clear. Faulty gating would leak non-zero read data, let writes through, or hide the privilege bit itself from unprivileged reads.

// File: rtl/otf_rf_pkg.sv
`timescale 1ns/1ps
package otf_rf_pkg;
  localparam int WORD_W = 32;
  localparam int VER_W  = 16;
  localparam int MODE_W = 2;
  localparam int CRC_W  = 8;

  // bit positions inside a region configuration word
  localparam int B_EN    = 0;
  localparam int B_CLOCK = 1;
  localparam int B_KLOCK = 2;
  localparam int B_MODE  = 4;
  localparam int B_CRC   = 8;
  localparam int B_VER   = 16;

  typedef enum logic [2:0] {
    W_CFG    = 3'd0,
    W_START  = 3'd1,
    W_END    = 3'd2,
    W_NONCE0 = 3'd3,
    W_NONCE1 = 3'd4,
    W_NONE   = 3'd7
  } rgn_word_e;

  typedef struct packed {
    logic [VER_W-1:0]  ver;
    logic [MODE_W-1:0] mode;
    logic              klock;
    logic              clock;
    logic              en;
  } rgn_cfg_t;
endpackage

// File: rtl/otf_rf_decode.sv
`timescale 1ns/1ps
module otf_rf_decode
  import otf_rf_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int N_RGN      = 4,
  parameter int RGN_BASE   = 32,
  parameter int RGN_STRIDE = 48,
  parameter int CTRL_OFS   = 0,
  parameter int PRIV_OFS   = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ctrl,
  output logic              hit_priv,
  output logic [N_RGN-1:0]  rgn_hit,
  output rgn_word_e         word
);
  localparam int WORD_BYTES = WORD_W / 8;

  logic aligned;
  assign aligned  = (addr[1:0] == 2'b00);
  assign hit_ctrl = aligned && (int'(addr) == CTRL_OFS);
  assign hit_priv = aligned && (int'(addr) == PRIV_OFS);

  always_comb begin
    rgn_hit = '0;
    word    = W_NONE;
    for (int i = 0; i < N_RGN; i++) begin
      if (aligned && int'(addr) >= RGN_BASE + i*RGN_STRIDE &&
          int'(addr) < RGN_BASE + (i+1)*RGN_STRIDE) begin
        rgn_hit[i] = 1'b1;
        case ((int'(addr) - RGN_BASE - i*RGN_STRIDE) / WORD_BYTES)
          0:       word = W_CFG;
          1:       word = W_START;
          2:       word = W_END;
          3:       word = W_NONCE0;
          4:       word = W_NONCE1;
          default: word = W_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/otf_rgn_ctx.sv
`timescale 1ns/1ps
module otf_rgn_ctx
  import otf_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  rgn_word_e         word,
  input  logic [WORD_W-1:0] wdata,
  output rgn_cfg_t          cfg_o,
  output logic [WORD_W-1:0] start_o,
  output logic [WORD_W-1:0] end_o,
  output logic [WORD_W-1:0] nonce0_o,
  output logic [WORD_W-1:0] nonce1_o,
  output logic              key_clr_o
);
  rgn_cfg_t          cfg_q;
  logic [MODE_W-1:0] wr_mode;

  assign wr_mode = wdata[B_MODE +: MODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      start_o   <= '0;
      end_o     <= '0;
      nonce0_o  <= '0;
      nonce1_o  <= '0;
      key_clr_o <= 1'b0;
    end else begin
      key_clr_o <= 1'b0;
      if (wr_en && !cfg_q.clock) begin
        case (word)
          W_CFG: begin
            cfg_q.en    <= wdata[B_EN];
            cfg_q.ver   <= wdata[B_VER +: VER_W];
            cfg_q.clock <= cfg_q.clock | wdata[B_CLOCK];
            cfg_q.klock <= cfg_q.klock | wdata[B_KLOCK] | wdata[B_CLOCK];
            if (!cfg_q.klock) begin
              cfg_q.mode <= wr_mode;
              key_clr_o  <= (wr_mode != cfg_q.mode);
            end
          end
          W_START:  start_o  <= wdata;
          W_END:    end_o    <= wdata;
          W_NONCE0: nonce0_o <= wdata;
          W_NONCE1: nonce1_o <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign cfg_o = cfg_q;

  assert_cfg_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_q.clock |=> cfg_q.clock);
  assert_key_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_q.klock |=> cfg_q.klock);
  assert_cfg_forces_key_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_q.clock |-> cfg_q.klock);
  assert_locked_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_q.clock |=> ($stable(cfg_q) && $stable(start_o) && $stable(end_o) &&
                     $stable(nonce0_o) && $stable(nonce1_o)));
  assert_clear_on_mode_R8: assert property (@(posedge clk) disable iff (rst)
    key_clr_o |-> (cfg_q.mode != $past(cfg_q.mode)));
  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_q.klock |=> $stable(cfg_q.mode));
endmodule

// File: rtl/otf_region_regfile.sv
`timescale 1ns/1ps
module otf_region_regfile
  import otf_rf_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int N_RGN      = 4,
  parameter int RGN_BASE   = 32,
  parameter int RGN_STRIDE = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_req,
  input  logic                     bus_we,
  input  logic                     bus_priv,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic [CRC_W*N_RGN-1:0]   rgn_key_crc_i,
  output logic [31:0]              bus_rdata,
  output logic                     bus_rvalid,
  output logic                     ctl_encrypt_o,
  output logic [N_RGN-1:0]         rgn_en_o,
  output logic [MODE_W*N_RGN-1:0]  rgn_mode_o,
  output logic [VER_W*N_RGN-1:0]   rgn_ver_o,
  output logic [N_RGN-1:0]         rgn_cfg_lock_o,
  output logic [N_RGN-1:0]         rgn_key_lock_o,
  output logic [N_RGN-1:0]         rgn_key_clr_o
);
  localparam int CTRL_OFS = 0;
  localparam int PRIV_OFS = 16;

  logic             hit_ctrl, hit_priv;
  logic [N_RGN-1:0] rgn_hit;
  rgn_word_e        word;
  logic             enc_q, priv_q;
  logic             gated, wr_ok, rd_req;
  logic [WORD_W-1:0] rd_val;

  rgn_cfg_t          cfg    [N_RGN];
  logic [WORD_W-1:0] st     [N_RGN];
  logic [WORD_W-1:0] ed     [N_RGN];
  logic [WORD_W-1:0] n0     [N_RGN];
  logic [WORD_W-1:0] n1     [N_RGN];

  otf_rf_decode #(
    .ADDR_W(ADDR_W), .N_RGN(N_RGN), .RGN_BASE(RGN_BASE),
    .RGN_STRIDE(RGN_STRIDE), .CTRL_OFS(CTRL_OFS), .PRIV_OFS(PRIV_OFS)
  ) dec_i (
    .addr(bus_addr), .hit_ctrl(hit_ctrl), .hit_priv(hit_priv),
    .rgn_hit(rgn_hit), .word(word)
  );

  assign gated  = priv_q && !bus_priv;
  assign wr_ok  = bus_req && bus_we && !gated;
  assign rd_req = bus_req && !bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_q  <= 1'b0;
      priv_q <= 1'b0;
    end else begin
      if (wr_ok && hit_ctrl) enc_q <= bus_wdata[0];
      if (bus_req && bus_we && bus_priv && hit_priv) priv_q <= bus_wdata[0];
    end
  end

  for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
    otf_rgn_ctx ctx_i (
      .clk(clk), .rst(rst), .wr_en(wr_ok && rgn_hit[g]), .word(word),
      .wdata(bus_wdata), .cfg_o(cfg[g]), .start_o(st[g]), .end_o(ed[g]),
      .nonce0_o(n0[g]), .nonce1_o(n1[g]), .key_clr_o(rgn_key_clr_o[g])
    );
    assign rgn_en_o[g]                   = cfg[g].en;
    assign rgn_mode_o[g*MODE_W +: MODE_W] = cfg[g].mode;
    assign rgn_ver_o[g*VER_W +: VER_W]    = cfg[g].ver;
    assign rgn_cfg_lock_o[g]             = cfg[g].clock;
    assign rgn_key_lock_o[g]             = cfg[g].klock;
  end

  always_comb begin
    rd_val = '0;
    if (hit_priv) begin
      rd_val[0] = priv_q;
    end else if (!gated) begin
      if (hit_ctrl) rd_val[0] = enc_q;
      for (int i = 0; i < N_RGN; i++) begin
        if (rgn_hit[i]) begin
          case (word)
            W_CFG: begin
              rd_val[B_VER +: VER_W]   = cfg[i].ver;
              rd_val[B_CRC +: CRC_W]   = rgn_key_crc_i[i*CRC_W +: CRC_W];
              rd_val[B_MODE +: MODE_W] = cfg[i].mode;
              rd_val[B_KLOCK]          = cfg[i].klock;
              rd_val[B_CLOCK]          = cfg[i].clock;
              rd_val[B_EN]             = cfg[i].en;
            end
            W_START:  rd_val = st[i];
            W_END:    rd_val = ed[i];
            W_NONCE0: rd_val = n0[i];
            W_NONCE1: rd_val = n1[i];
            default:  rd_val = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      bus_rdata  <= rd_req ? rd_val : '0;
    end
  end

  assign ctl_encrypt_o = enc_q;

  assert_one_region_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rgn_hit));
  assert_gated_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && gated && !hit_priv) |=> (bus_rdata == '0));
  assert_priv_write_R10: assert property (@(posedge clk) disable iff (rst)
    (priv_q != $past(priv_q)) |-> $past(bus_req && bus_we && bus_priv));
  assert_read_valid_R12: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);
endmodule

// File: tb/otf_region_regfile_tb_top.sv
`timescale 1ns/1ps
module otf_region_regfile_tb_top;
  localparam int NR = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst;
  always #2.5 clk = ~clk;

  logic          bus_req, bus_we, bus_priv;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          bus_rvalid, ctl_encrypt_o;
  logic [8*NR-1:0]  rgn_key_crc_i;
  logic [NR-1:0]    rgn_en_o, rgn_cfg_lock_o, rgn_key_lock_o, rgn_key_clr_o;
  logic [2*NR-1:0]  rgn_mode_o;
  logic [16*NR-1:0] rgn_ver_o;

  otf_region_regfile dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_priv(bus_priv),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rgn_key_crc_i(rgn_key_crc_i),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .ctl_encrypt_o(ctl_encrypt_o),
    .rgn_en_o(rgn_en_o), .rgn_mode_o(rgn_mode_o), .rgn_ver_o(rgn_ver_o),
    .rgn_cfg_lock_o(rgn_cfg_lock_o), .rgn_key_lock_o(rgn_key_lock_o),
    .rgn_key_clr_o(rgn_key_clr_o)
  );

  int checks = 0;
  int fails  = 0;

  // reference model
  bit        m_enc, m_priv;
  bit        m_en [NR], m_cl [NR], m_kl [NR];
  bit [1:0]  m_mode [NR];
  bit [15:0] m_ver [NR];
  bit [31:0] m_st [NR], m_ed [NR], m_n0 [NR], m_n1 [NR];
  bit [NR-1:0] exp_clr;

  function automatic logic [7:0] crc_of(int i);
    return 8'(8'hA0 + 8'(i * 17));
  endfunction

  function automatic logic [AW-1:0] ra(int i, int ofs);
    return AW'(32 + 48*i + ofs);
  endfunction

  function automatic void model_reset();
    m_enc = 0; m_priv = 0; exp_clr = '0;
    for (int i = 0; i < NR; i++) begin
      m_en[i] = 0; m_cl[i] = 0; m_kl[i] = 0; m_mode[i] = 0; m_ver[i] = 0;
      m_st[i] = 0; m_ed[i] = 0; m_n0[i] = 0; m_n1[i] = 0;
    end
  endfunction

  function automatic int rgn_of(logic [AW-1:0] a);
    if (a[1:0] != 2'b00) return -1;
    for (int i = 0; i < NR; i++)
      if (int'(a) >= 32 + 48*i && int'(a) < 80 + 48*i) return i;
    return -1;
  endfunction

  function automatic logic [31:0] model_read(logic [AW-1:0] a, bit p);
    int r;
    if (a == 8'h10) return {31'd0, m_priv};
    if (m_priv && !p) return 32'd0;
    if (a == 8'h00) return {31'd0, m_enc};
    r = rgn_of(a);
    if (r < 0) return 32'd0;
    case ((int'(a) - 32 - 48*r) / 4)
      0: return {m_ver[r], crc_of(r), 2'b00, m_mode[r], 1'b0, m_kl[r], m_cl[r], m_en[r]};
      1: return m_st[r];
      2: return m_ed[r];
      3: return m_n0[r];
      4: return m_n1[r];
      default: return 32'd0;
    endcase
  endfunction

  function automatic void model_write(logic [AW-1:0] a, logic [31:0] d, bit p);
    int r;
    exp_clr = '0;
    if (a == 8'h10 && p) m_priv = d[0];
    if (m_priv && !p) return;
    if (a == 8'h00) m_enc = d[0];
    r = rgn_of(a);
    if (r < 0 || m_cl[r]) return;
    case ((int'(a) - 32 - 48*r) / 4)
      0: begin
        m_en[r] = d[0]; m_ver[r] = d[31:16];
        if (!m_kl[r]) begin
          if (d[5:4] != m_mode[r]) exp_clr[r] = 1'b1;
          m_mode[r] = d[5:4];
        end
        m_kl[r] = m_kl[r] | d[2] | d[1];
        m_cl[r] = m_cl[r] | d[1];
      end
      1: m_st[r] = d;
      2: m_ed[r] = d;
      3: m_n0[r] = d;
      4: m_n1[r] = d;
      default: ;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    logic [NR-1:0] e_en, e_cl, e_kl;
    logic [2*NR-1:0] e_mode;
    logic [16*NR-1:0] e_ver;
    for (int i = 0; i < NR; i++) begin
      e_en[i] = m_en[i]; e_cl[i] = m_cl[i]; e_kl[i] = m_kl[i];
      e_mode[2*i +: 2] = m_mode[i]; e_ver[16*i +: 16] = m_ver[i];
    end
    check({tag, " enc"},  64'(ctl_encrypt_o), 64'(m_enc));
    check({tag, " en"},   64'(rgn_en_o),       64'(e_en));
    check({tag, " mode"}, 64'(rgn_mode_o),     64'(e_mode));
    check({tag, " ver"},  64'(rgn_ver_o),      64'(e_ver));
    check({tag, " lock"}, 64'({rgn_cfg_lock_o, rgn_key_lock_o}), 64'({e_cl, e_kl}));
  endtask

  // one bus access; results are sampled one full cycle after the driving edge
  task automatic access(bit we, logic [AW-1:0] a, logic [31:0] d, bit p, string tag);
    logic [31:0] exp_rd;
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d; bus_priv = p;
    exp_rd = model_read(a, p);
    if (we) model_write(a, d, p); else exp_clr = '0;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    check("R12 rvalid", 64'(bus_rvalid), 64'(!we));
    if (!we) check(tag, 64'(bus_rdata), 64'(exp_rd));
    check("R8 key clear strobe", 64'(rgn_key_clr_o), 64'(exp_clr));
    check_outputs("R12 state");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; bus_req = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) rgn_key_crc_i[8*i +: 8] = crc_of(i);
    bus_req = 0; bus_we = 0; bus_priv = 1; bus_addr = '0; bus_wdata = '0;
    rst = 1;
    do_reset();

    // R1: reset state
    check_outputs("R1 reset");
    check("R1 clear strobe", 64'(rgn_key_clr_o), 64'(0));
    access(0, 8'h00, 0, 1, "R1 ctrl reset");
    access(0, 8'h10, 0, 1, "R1 priv reset");
    for (int i = 0; i < NR; i++) access(0, ra(i, 0), 0, 1, "R1 cfg reset");

    // R2: control word
    access(1, 8'h00, 32'h1, 1, "R2");
    access(0, 8'h00, 0, 1, "R2 readback");
    access(1, 8'h00, 32'hFFFF_FFFE, 1, "R2");
    access(0, 8'h00, 0, 1, "R2 clear readback");

    // R3: region map
    for (int i = 0; i < NR; i++) begin
      access(1, ra(i, 4),  32'h1000_0000 + 32'(i), 1, "R3");
      access(1, ra(i, 8),  32'h2000_0000 + 32'(i), 1, "R3");
      access(1, ra(i, 12), 32'hC0DE_0000 + 32'(i), 1, "R3");
      access(1, ra(i, 16), 32'h5A5A_0000 + 32'(i), 1, "R3");
    end
    for (int i = 0; i < NR; i++)
      for (int w = 1; w < 5; w++) access(0, ra(i, 4*w), 0, 1, "R3 readback");

    // R4: configuration layout, reserved bits
    access(1, ra(1, 0), 32'hABCD_FFF9, 1, "R4");
    access(0, ra(1, 0), 0, 1, "R4 cfg readback");

    // R8: same mode -> no strobe, new mode -> strobe
    access(1, ra(1, 0), 32'h1234_0030, 1, "R8 same mode");
    access(1, ra(1, 0), 32'h1234_0020, 1, "R8 new mode");

    // R11: unmapped, key words, misaligned
    access(1, ra(0, 20), 32'hDEAD_BEEF, 1, "R11");
    access(0, ra(0, 20), 0, 1, "R11 key word reads zero");
    access(1, ra(2, 5), 32'hFFFF_FFFF, 1, "R11");
    access(0, ra(2, 4), 0, 1, "R11 misaligned write ignored");
    access(0, 8'h04, 0, 1, "R11 gap");
    access(0, 8'hE0, 0, 1, "R11 past end");
    access(1, 8'hFC, 32'hFFFF_FFFF, 1, "R11");
    access(0, 8'hFC, 0, 1, "R11 top");

    // R9 / R10: privilege
    access(1, 8'h10, 32'h1, 0, "R10 unpriv set ignored");
    access(0, 8'h10, 0, 1, "R10 priv still clear");
    access(1, 8'h10, 32'h1, 1, "R10 priv set");
    access(0, 8'h10, 0, 0, "R10 unpriv read of priv");
    access(0, 8'h00, 0, 0, "R9 unpriv ctrl read");
    access(0, ra(0, 4), 0, 0, "R9 unpriv start read");
    access(1, 8'h00, 32'h0, 0, "R9 unpriv write");
    access(1, ra(0, 0), 32'h0000_0011, 0, "R9 unpriv cfg write");
    access(0, ra(0, 0), 0, 1, "R9 cfg unchanged");
    access(1, 8'h10, 32'h0, 0, "R10 unpriv clear ignored");
    access(0, 8'h10, 0, 0, "R10 priv still set");
    access(1, 8'h10, 32'h0, 1, "R10 priv clear");

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = int'($urandom % 10);
      if (sel < 7)       a = ra(int'($urandom % NR), 4 * int'($urandom % 12));
      else if (sel == 7) a = 8'h00;
      else if (sel == 8) a = 8'h10;
      else               a = AW'($urandom);
      d = $urandom;
      if ($urandom % 25 != 0) d[2:1] = 2'b00;
      access(bit'($urandom % 2), a, d, ($urandom % 4) != 0, "R3 random");
    end

    // locks: R5, R6, R7, R8
    do_reset();
    access(1, ra(2, 0), 32'h0001_0024, 1, "R5 key lock");
    access(1, ra(2, 0), 32'h0002_0010, 1, "R8 mode frozen by key lock");
    access(0, ra(2, 0), 0, 1, "R5 key lock kept");
    access(1, ra(2, 0), 32'h0003_0002, 1, "R6 cfg lock");
    access(1, ra(2, 0), 32'h0000_0000, 1, "R5 zero write");
    access(0, ra(2, 0), 0, 1, "R5 locks kept");
    access(1, ra(3, 0), 32'h00AA_0013, 1, "R6 cfg lock forces key lock");
    access(0, ra(3, 0), 0, 1, "R6 readback");
    access(1, ra(3, 4), 32'h7777_7777, 1, "R7");
    access(1, ra(3, 16), 32'h8888_8888, 1, "R7");
    access(1, ra(3, 0), 32'h0055_0020, 1, "R7 cfg frozen");
    access(0, ra(3, 4), 0, 1, "R7 start frozen");
    access(0, ra(3, 16), 0, 1, "R7 nonce frozen");
    access(0, ra(3, 0), 0, 1, "R7 cfg readback");
    do_reset();
    check_outputs("R5 reset clears locks");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule